// File: doc/BRIEF.md
# External Bus Strobe Sequencer

This block drives the address-latch strobe (ALE, active high) and the program-store read strobe (PSEN, active low) of an 8051-style external memory bus. It runs on the oscillator clock. It splits each machine cycle into six phases and reports the current phase on a phase index, so that a bus controller can place address and data on the bus. A machine cycle lasts twelve oscillator periods in standard mode, with two periods per phase. In double-speed mode it lasts six periods, with one period per phase.

The kind of machine cycle is given as a code, and that code decides which strobes the cycle emits. An external code fetch produces two ALE pulses and two PSEN read windows. An external data access keeps only the first ALE pulse and emits no PSEN. An internal fetch never drives PSEN. On an internal fetch, ALE pulses normally unless the ALE-off control is set, in which case ALE stays low. The cycle code, the ALE-off control and the speed mode are captured only at machine-cycle boundaries, so no strobe is ever cut short.

Top module: `ext_bus_strobe_seq`

## Requirements
- R1: While rst_ni is low, ale_o is 0, psen_n_o is 1 and phase_o is 0, whatever the other inputs do.
- R2: phase_o steps 0,1,2,3,4,5 and then wraps to 0. Each phase lasts two clock cycles when the latched mode is standard (x2_mode_i=0) and one clock cycle when it is double-speed (x2_mode_i=1).
- R3: In an external code fetch cycle (cyc_type_i=2'b01), ale_o is 1 in phases 0 and 3, and psen_n_o is 0 in phases 1 and 4. At all other times ale_o is 0 and psen_n_o is 1.
- R4: In an external data cycle (cyc_type_i=2'b10), ale_o is 1 in phase 0 only, and psen_n_o stays 1 for the whole cycle.
- R5: In an internal fetch cycle (cyc_type_i=2'b00, with 2'b11 treated the same), psen_n_o stays 1 for the whole cycle. If ale_off_i=0, ale_o is 1 in phases 0 and 3.
- R6: With ale_off_i=1, ale_o stays 0 for a whole internal fetch cycle. ale_off_i has no effect on external code or external data cycles.
- R7: cyc_type_i and ale_off_i are sampled on the clock edge that starts a machine cycle. Changes to them later in that cycle have no effect until the next cycle starts.
- R8: x2_mode_i is sampled only on the clock edge that starts a machine cycle. Toggling it mid-cycle changes neither the phase lengths nor the strobe lengths of the current cycle.
- R9: The first clock edge after rst_ni rises starts a new machine cycle in phase 0, using the inputs present at that edge. This holds even when reset arrived in the middle of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x2_mode_i | input | 1 | 1 = six-period machine cycle, 0 = twelve-period |
| ale_off_i | input | 1 | Suppresses ALE during internal fetch cycles |
| cyc_type_i | input | 2 | Cycle code: 00 internal, 01 external code, 10 external data, 11 internal |
| ale_o | output | 1 | Address latch strobe, active high |
| psen_n_o | output | 1 | Program store read strobe, active low |
| phase_o | output | 3 | Current phase of the machine cycle, 0 to 5 |

## Verification
The hardest case to reach from the ports is an input change that lands inside a machine cycle. This matters most for the speed mode, where an early capture would shorten the phases of the cycle already under way. The bench sweeps every cycle code, speed mode and ALE-off setting. In the scrambled variant of each case, it flips the mode and the ALE-off control and changes the cycle code on every clock from the second one until the cycle's last clock. It then checks that the phase timing and both strobes still follow the values captured at the boundary. A reset that arrives part-way through a cycle is also applied, followed by a check that the next cycle restarts cleanly at phase 0.

// File: rtl/ext_strobe_pkg.sv
package ext_strobe_pkg;
  localparam int unsigned NUM_PHASES = 6;
  localparam int unsigned TICKS_STD  = 2;
  localparam int unsigned TICKS_FAST = 1;
  localparam int unsigned ALE_SLOTS  = 2;

  typedef enum logic [1:0] {
    CYC_INT      = 2'b00,
    CYC_EXT_CODE = 2'b01,
    CYC_EXT_DATA = 2'b10,
    CYC_INT_ALT  = 2'b11
  } cyc_type_e;
endpackage

// File: rtl/esb_phase_timer.sv
module esb_phase_timer #(
  parameter int unsigned NUM_PHASES = 6,
  parameter int unsigned TICKS_STD  = 2,
  parameter int unsigned TICKS_FAST = 1,
  localparam int unsigned PH_W      = $clog2(NUM_PHASES),
  localparam int unsigned TICK_W    = (TICKS_STD > 1) ? $clog2(TICKS_STD) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fast_q_i,
  output logic            load_o,
  output logic            active_o,
  output logic [PH_W-1:0] phase_o
);
  logic              started_q;
  logic [TICK_W-1:0] tick_q;
  logic [PH_W-1:0]   phase_q;
  logic [TICK_W-1:0] tick_max;
  logic              tick_last, phase_last;

  assign tick_max   = fast_q_i ? TICK_W'(TICKS_FAST - 1) : TICK_W'(TICKS_STD - 1);
  assign tick_last  = (tick_q == tick_max);
  assign phase_last = (phase_q == PH_W'(NUM_PHASES - 1));
  // a cycle boundary also follows reset release
  assign load_o     = !started_q || (tick_last && phase_last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      started_q <= 1'b0;
      tick_q    <= '0;
      phase_q   <= '0;
    end else if (load_o) begin
      started_q <= 1'b1;
      tick_q    <= '0;
      phase_q   <= '0;
    end else if (tick_last) begin
      tick_q    <= '0;
      phase_q   <= phase_q + PH_W'(1);
    end else begin
      tick_q    <= tick_q + TICK_W'(1);
    end
  end

  assign active_o = started_q;
  assign phase_o  = phase_q;
endmodule

// File: rtl/esb_cycle_latch.sv
module esb_cycle_latch
  import ext_strobe_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      load_i,
  input  logic      fast_i,
  input  logic      ale_off_i,
  input  logic [1:0] cyc_i,
  output logic      fast_q_o,
  output logic      ale_off_q_o,
  output cyc_type_e cyc_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fast_q_o    <= 1'b0;
      ale_off_q_o <= 1'b0;
      cyc_q_o     <= CYC_INT;
    end else if (load_i) begin
      fast_q_o    <= fast_i;
      ale_off_q_o <= ale_off_i;
      cyc_q_o     <= cyc_type_e'(cyc_i);
    end
  end
endmodule

// File: rtl/esb_strobe_decode.sv
module esb_strobe_decode
  import ext_strobe_pkg::*;
#(
  parameter int unsigned NUM_PHASES = 6,
  parameter int unsigned ALE_SLOTS  = 2,
  localparam int unsigned PH_W      = $clog2(NUM_PHASES),
  localparam int unsigned SLOT_LEN  = NUM_PHASES / ALE_SLOTS
) (
  input  logic            active_i,
  input  logic [PH_W-1:0] phase_i,
  input  cyc_type_e       cyc_i,
  input  logic            ale_off_i,
  output logic            ale_o,
  output logic            psen_n_o
);
  logic [ALE_SLOTS-1:0] ale_slot, psen_slot;
  logic is_code, is_data, is_int;

  assign is_code = (cyc_i == CYC_EXT_CODE);
  assign is_data = (cyc_i == CYC_EXT_DATA);
  assign is_int  = !is_code && !is_data;

  for (genvar g = 0; g < ALE_SLOTS; g++) begin : g_slot
    localparam int unsigned ALE_PH = g * SLOT_LEN;
    logic keep;
    // data cycles keep the first ALE only; internal cycles honour ale_off
    if (g == 0) begin : g_first
      assign keep = is_code || is_data || !ale_off_i;
    end else begin : g_rest
      assign keep = is_code || (is_int && !ale_off_i);
    end
    assign ale_slot[g]  = keep && (phase_i == PH_W'(ALE_PH));
    assign psen_slot[g] = is_code && (phase_i == PH_W'(ALE_PH + 1));
  end

  assign ale_o    = active_i && (|ale_slot);
  assign psen_n_o = !(active_i && (|psen_slot));
endmodule

// File: rtl/ext_bus_strobe_seq.sv
module ext_bus_strobe_seq
  import ext_strobe_pkg::*;
#(
  parameter int unsigned NUM_PHASES_P = ext_strobe_pkg::NUM_PHASES,
  parameter int unsigned TICKS_STD_P  = ext_strobe_pkg::TICKS_STD,
  parameter int unsigned TICKS_FAST_P = ext_strobe_pkg::TICKS_FAST,
  parameter int unsigned ALE_SLOTS_P  = ext_strobe_pkg::ALE_SLOTS,
  localparam int unsigned PH_W        = $clog2(NUM_PHASES_P)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            x2_mode_i,
  input  logic            ale_off_i,
  input  logic [1:0]      cyc_type_i,
  output logic            ale_o,
  output logic            psen_n_o,
  output logic [PH_W-1:0] phase_o
);
  logic      load, active;
  logic      x2_q, ale_off_q;
  cyc_type_e cyc_q;

  esb_phase_timer #(
    .NUM_PHASES(NUM_PHASES_P),
    .TICKS_STD (TICKS_STD_P),
    .TICKS_FAST(TICKS_FAST_P)
  ) i_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fast_q_i(x2_q),
    .load_o  (load),
    .active_o(active),
    .phase_o (phase_o)
  );

  esb_cycle_latch i_latch (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .fast_i     (x2_mode_i),
    .ale_off_i  (ale_off_i),
    .cyc_i      (cyc_type_i),
    .fast_q_o   (x2_q),
    .ale_off_q_o(ale_off_q),
    .cyc_q_o    (cyc_q)
  );

  esb_strobe_decode #(
    .NUM_PHASES(NUM_PHASES_P),
    .ALE_SLOTS (ALE_SLOTS_P)
  ) i_decode (
    .active_i (active),
    .phase_i  (phase_o),
    .cyc_i    (cyc_q),
    .ale_off_i(ale_off_q),
    .ale_o    (ale_o),
    .psen_n_o (psen_n_o)
  );
endmodule

// File: rtl/esb_strobe_checker.sv
module esb_strobe_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ale_o,
  input logic       psen_n_o,
  input logic [2:0] phase_o,
  input logic       x2_q,
  input logic       ale_off_q,
  input logic [1:0] cyc_q
);
  assert_reset_idle_R1: assert property (@(negedge clk_i)
    !rst_ni |-> (!ale_o && psen_n_o && phase_o == 3'd0));

  assert_phase_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    phase_o < 3'd6);

  assert_phase_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != $past(phase_o)) |-> (phase_o == $past(phase_o) + 3'd1 || phase_o == 3'd0));

  assert_ale_phase_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |-> (phase_o == 3'd0 || phase_o == 3'd3));

  assert_psen_phase_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !psen_n_o |-> ((phase_o == 3'd1 || phase_o == 3'd4) && cyc_q == 2'b01));

  assert_no_overlap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ale_o && !psen_n_o));

  assert_hold_type_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 3'd0) |-> ($stable(cyc_q) && $stable(ale_off_q)));

  assert_hold_mode_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 3'd0) |-> $stable(x2_q));
endmodule

bind ext_bus_strobe_seq esb_strobe_checker i_strobe_checker (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .ale_o    (ale_o),
  .psen_n_o (psen_n_o),
  .phase_o  (phase_o),
  .x2_q     (x2_q),
  .ale_off_q(ale_off_q),
  .cyc_q    (cyc_q)
);

// File: tb/test_ext_bus_strobe_seq.sv
module test_ext_bus_strobe_seq;
  logic       clk = 1'b0;
  logic       rst_ni;
  logic       x2_mode, ale_off;
  logic [1:0] cyc_type;
  logic       ale, psen_n;
  logic [2:0] phase;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;

  ext_bus_strobe_seq i_ext_bus_strobe_seq (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .x2_mode_i (x2_mode),
    .ale_off_i (ale_off),
    .cyc_type_i(cyc_type),
    .ale_o     (ale),
    .psen_n_o  (psen_n),
    .phase_o   (phase)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  // R1: hold reset for a few clocks while the inputs move
  task automatic hold_reset();
    rst_ni = 1'b0;
    for (int i = 0; i < 4; i++) begin
      cyc_type = 2'(i);
      x2_mode  = i[0];
      ale_off  = i[1];
      @(negedge clk);
      check("R1", "ale", int'(ale), 0);
      check("R1", "psen_n", int'(psen_n), 1);
      check("R1", "phase", int'(phase), 0);
    end
    rst_ni = 1'b1;
  endtask

  // Runs one machine cycle, starting at a negedge just before its boundary.
  // nclk = 0 runs the whole cycle; scramble flips the inputs mid-cycle.
  task automatic run_cycle(input logic [1:0] ty, input logic x2, input logic ad,
                           input bit scramble, input int nclk, input string first_tag);
    int t, len, stop;
    bit code, data, intl;
    t    = x2 ? 1 : 2;
    len  = 6 * t;
    stop = (nclk == 0) ? len : nclk;
    code = (ty == 2'b01);
    data = (ty == 2'b10);
    intl = !code && !data;
    cyc_type = ty;
    x2_mode  = x2;
    ale_off  = ad;
    for (int k = 0; k < stop; k++) begin
      int ph, ale_exp, psen_exp;
      string tp, ta;
      @(negedge clk);
      ph = k / t;
      if (ph == 0)      ale_exp = (intl && ad) ? 0 : 1;
      else if (ph == 3) ale_exp = (code || (intl && !ad)) ? 1 : 0;
      else              ale_exp = 0;
      psen_exp = (code && (ph == 1 || ph == 4)) ? 0 : 1;
      tp = scramble ? "R8" : "R2";
      if (scramble)   ta = "R7";
      else if (code)  ta = "R3";
      else if (data)  ta = ad ? "R6" : "R4";
      else            ta = ad ? "R6" : "R5";
      if (k == 0 && first_tag != "") begin
        tp = first_tag;
        ta = first_tag;
      end
      check(tp, "phase", int'(phase), ph);
      check(ta, "ale", int'(ale), ale_exp);
      check(ta, "psen_n", int'(psen_n), psen_exp);
      if (scramble && k < len - 1) begin
        cyc_type = ~ty;
        x2_mode  = ~x2;
        ale_off  = ~ad;
      end
    end
  endtask

  initial begin
    rst_ni   = 1'b0;
    x2_mode  = 1'b0;
    ale_off  = 1'b0;
    cyc_type = 2'b00;
    @(negedge clk);
    hold_reset();
    run_cycle(2'b01, 1'b0, 1'b0, 1'b0, 0, "R9");
    // full sweep: code x mode x ale_off x scramble
    for (int ty = 0; ty < 4; ty++)
      for (int m = 0; m < 2; m++)
        for (int a = 0; a < 2; a++)
          for (int s = 0; s < 2; s++)
            run_cycle(2'(ty), m[0], a[0], s[0], 0, "");
    // back-to-back mode switches at boundaries
    run_cycle(2'b01, 1'b1, 1'b0, 1'b0, 0, "");
    run_cycle(2'b01, 1'b0, 1'b0, 1'b0, 0, "");
    run_cycle(2'b10, 1'b1, 1'b1, 1'b0, 0, "");
    // reset landing mid-cycle, then restart
    run_cycle(2'b01, 1'b0, 1'b0, 1'b0, 5, "");
    hold_reset();
    run_cycle(2'b01, 1'b1, 1'b0, 1'b0, 0, "R9");
    run_cycle(2'b00, 1'b0, 1'b1, 1'b1, 0, "");
    run_cycle(2'b10, 1'b0, 1'b0, 1'b0, 0, "");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 200000; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule